// File: doc/BRIEF.md
# Radix-4 Recoded 8x8 Multiplier

This block multiplies two 8-bit operands and returns a 16-bit product. One mode input chooses how both operands are read: as two's complement numbers or as plain unsigned magnitudes. The result is held in a single output register. It is therefore valid one clock after the operands and the mode are applied, and a new operand pair can be accepted on every cycle.

Internally, the multiplier operand is recoded into signed base-4 digits. Each digit is taken from an overlapping window of three bits, so each digit picks zero, one or two times the multiplicand, either added or subtracted. In unsigned mode the multiplier is widened by two zero bits, which gives five digits. A negative digit uses the bit-inverted multiple. The +1 that completes the negation is collected in a separate correction row. The rows pass through a three-level carry-save tree, and a parallel-prefix look-ahead adder combines the two remaining rows. The top bits above 16 are discarded, so the result is the exact product taken modulo 2^16.

Top module: `booth_r4_mult`

## Requirements
- R1: With `signed_mode`=0, `product` equals the unsigned product of `op_a` and `op_b`, from 0 up to 65025.
- R2: With `signed_mode`=1, both operands are two's complement values in the range -128..127, and `product` is their exact 16-bit two's complement product.
- R3: `product` changes only at a rising clock edge. After an edge it shows the result for the operands and mode that were present at that edge. A change of the inputs between edges does not change `product`.
- R4: While `rst_n` is low, `product` is 0. The reset is asynchronous, active low, and also takes effect at a clock edge.
- R5: The extreme cases are exact: 255*255 gives 65025 (0xFE01) in unsigned mode. In signed mode, -128*-128 gives 16384 (0x4000) and -128*127 gives -16256 (0xC080).
- R6: The same operand bits give different results depending on the mode. For example, 0xFF*0xFF gives 0xFE01 unsigned and 0x0001 signed, and 0x80*0x02 gives 0x0100 unsigned and 0xFF00 signed.
- R7: If either operand is zero, `product` is 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register captures on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | 8 | Multiplicand |
| op_b | input | 8 | Multiplier operand; this is the operand that is recoded |
| signed_mode | input | 1 | 1: both operands are two's complement; 0: both are unsigned |
| product | output | 16 | Registered 16-bit product |

## Verification
The hardest paths to reach are the ones where the recoded digit is -2. The most demanding case is a multiplier with its top bit set in unsigned mode: the fifth digit is then non-zero, and the correction bits and the top carry all have to combine correctly. Any single hand-picked vector reaches only a few of these combinations. The stimulus therefore sweeps every operand pair in both modes, one pair per clock. The mode-dependent pairs and the reset are also driven as explicit sequences.

// File: rtl/booth_r4_mult.sv
module booth_r4_mult (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  op_a,
  input  logic [7:0]  op_b,
  input  logic        signed_mode,
  output logic [15:0] product
);

  logic        ext_a, ext_b;
  logic [10:0] mb_z;
  logic [15:0] mult1, mult2;
  logic [15:0] rows [6];
  logic [15:0] s1, c1, s2, c2, s3, c3, s4, c4;
  logic [15:0] gen, prop, sum;
  logic [15:0] gl [5];
  logic [15:0] pl [5];

  assign ext_a = signed_mode & op_a[7];
  assign ext_b = signed_mode & op_b[7];
  assign mb_z  = {ext_b, ext_b, op_b, 1'b0};
  assign mult1 = {{8{ext_a}}, op_a};
  assign mult2 = {mult1[14:0], 1'b0};

  always_comb begin
    rows[5] = '0;
    for (int i = 0; i < 5; i++) begin
      logic [2:0]  trip;
      logic        one, two, neg;
      logic [15:0] sel;
      trip = mb_z[2*i +: 3];
      one  = trip[1] ^ trip[0];
      two  = (trip == 3'b011) || (trip == 3'b100);
      neg  = trip[2] & ~(trip[1] & trip[0]);
      sel  = one ? mult1 : (two ? mult2 : 16'd0);
      rows[i] = (neg ? ~sel : sel) << (2*i);
      rows[5][2*i] = neg;
    end
  end

  function automatic logic [31:0] csa(input logic [15:0] x, y, z);
    logic [15:0] s, c;
    s = x ^ y ^ z;
    c = ((x & y) | (x & z) | (y & z)) << 1;
    return {s, c};
  endfunction

  assign {s1, c1} = csa(rows[0], rows[1], rows[2]);
  assign {s2, c2} = csa(rows[3], rows[4], rows[5]);
  assign {s3, c3} = csa(s1, c1, s2);
  assign {s4, c4} = csa(s3, c3, c2);

  assign gen  = s4 & c4;
  assign prop = s4 ^ c4;

  always_comb begin
    gl[0] = gen;
    pl[0] = prop;
    for (int lv = 0; lv < 4; lv++) begin
      for (int i = 0; i < 16; i++) begin
        if (i >= (1 << lv)) begin
          gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][i - (1 << lv)]);
          pl[lv+1][i] = pl[lv][i] & pl[lv][i - (1 << lv)];
        end else begin
          gl[lv+1][i] = gl[lv][i];
          pl[lv+1][i] = pl[lv][i];
        end
      end
    end
  end

  assign sum = prop ^ {gl[4][14:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) product <= '0;
    else        product <= sum;

endmodule

// File: rtl/booth_r4_mult_chk.sv
module booth_r4_mult_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  op_a,
  input logic [7:0]  op_b,
  input logic        signed_mode,
  input logic [15:0] product
);

  logic        warm, rst_seen;
  logic [15:0] ref_u, ref_s;

  assign ref_u = {8'd0, op_a} * {8'd0, op_b};
  assign ref_s = {{8{op_a[7]}}, op_a} * {{8{op_b[7]}}, op_b};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) rst_seen <= 1'b1;

  p_unsigned_r1: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    !$past(signed_mode) |-> product == $past(ref_u));

  p_signed_r2: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    $past(signed_mode) |-> product == $past(ref_s));

  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    ($past(op_a) == 8'd0 || $past(op_b) == 8'd0) |-> product == 16'd0);

  p_reset_r4: assert property (@(posedge clk)
    (rst_seen === 1'b1 && !rst_n) |-> product == 16'd0);

endmodule

bind booth_r4_mult booth_r4_mult_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
  .signed_mode(signed_mode), .product(product)
);

// File: tb/booth_r4_mult_bench.sv
module booth_r4_mult_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  op_a = 0, op_b = 0;
  logic        signed_mode = 0;
  logic [15:0] product;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  booth_r4_mult u_booth_r4_mult (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .signed_mode(signed_mode), .product(product)
  );

  function automatic logic [15:0] model(logic [7:0] a, logic [7:0] b, logic s);
    int r;
    if (s) r = int'($signed(a)) * int'($signed(b));
    else   r = int'(a) * int'(b);
    return r[15:0];
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: product=%h expected=%h", tag, got, exp);
    end
  endtask

  // At each falling edge: compare the result of the previous drive, then drive anew.
  task automatic step(logic [7:0] a, logic [7:0] b, logic s, string tag);
    logic [15:0] held;
    @(negedge clk);
    if (exp_q.size() > 0) check(tag_q.pop_front(), product, exp_q.pop_front());
    held = product;
    op_a = a; op_b = b; signed_mode = s;
    #1 check("R3 no change between edges", product, held);
    exp_q.push_back(model(a, b, s));
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() > 0) check(tag_q.pop_front(), product, exp_q.pop_front());
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: run hung, got=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset value", product, 16'd0);
    rst_n = 1;

    step(8'hFF, 8'hFF, 1'b0, "R5 255*255");
    step(8'h80, 8'h80, 1'b1, "R5 -128*-128");
    step(8'h80, 8'h7F, 1'b1, "R5 -128*127");
    step(8'hFF, 8'hFF, 1'b1, "R6 FFxFF signed");
    step(8'h80, 8'h02, 1'b0, "R6 80x02 unsigned");
    step(8'h80, 8'h02, 1'b1, "R6 80x02 signed");
    step(8'h00, 8'h9C, 1'b1, "R7 zero a");
    step(8'hC3, 8'h00, 1'b0, "R7 zero b");
    drain();
    check("R5 literal 255*255", model(8'hFF, 8'hFF, 1'b0), 16'hFE01);
    check("R6 literal FFxFF signed", model(8'hFF, 8'hFF, 1'b1), 16'h0001);

    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          step(8'(a), 8'(b), 1'(s),
               (a == 0 || b == 0) ? "R7 zero operand" : (s != 0 ? "R2 signed sweep" : "R1 unsigned sweep"));
    drain();

    step(8'h7B, 8'h5A, 1'b0, "R1 before reset");
    drain();
    #3 rst_n = 0;
    #1 check("R4 async reset", product, 16'd0);
    @(negedge clk);
    check("R4 held in reset", product, 16'd0);
    rst_n = 1;
    step(8'h85, 8'h93, 1'b1, "R2 after reset");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule